// File: doc/BRIEF.md
# Serial EEPROM Slave Model (64 x 16)

This block behaves like a small three-wire serial EEPROM holding 64 words of 16 bits. A host raises the select line, then clocks a start bit, a two-bit opcode and a six-bit word address into the serial data input, one bit on each rising edge of the serial clock. Depending on the opcode the block sends a stored word back on the serial data output, clears a word to all ones, programs a word, or sets or clears an internal erase/write enable latch. The storage is an on-chip register array.

The protocol rules of a real part are kept. Modify commands are locked after reset until they are enabled. Programming can only clear bits, so a word must be erased before it can take an arbitrary value. Each accepted modify command starts a self-timed programming interval, measured in system clocks and set by a parameter. While that interval runs, the block ignores further commands and reports busy or ready on the data output. All pins are sampled with the system clock through a small synchronizer, so the serial clock must be much slower than `clk`.

Top module: `se_eeprom_slave`

## Requirements
- R1: After a synchronous reset the output enable `sdout_en` is low and the erase/write enable latch is cleared, so modify commands are locked.
- R2: While `sel` is high, leading 0 bits on `sdin` are skipped. The first 1 sampled on a rising `sclk` is the start bit. The next two bits form the opcode and the six bits after that form the word address, MSB first.
- R3: Opcode 2'b10 reads a word. On the rising edge that shifts in the last address bit, the output is enabled and shows a dummy 0. The next 16 rising edges present the stored word MSB first. The rising edge after the LSB releases `sdout_en`.
- R4: Opcode 2'b00 is an extended command decoded from the two top address bits. 2'b11 sets the enable latch, 2'b00 clears it, and any other value does nothing. While the latch is clear, opcodes 2'b01 and 2'b11 change no word and start no programming interval.
- R5: Opcode 2'b11 with the latch set erases the addressed word to 16'hFFFF.
- R6: Opcode 2'b01 with the latch set is followed by 16 data bits, MSB first. The addressed word becomes the bitwise AND of its old contents and the new data.
- R7: An accepted erase or write is programmed when `sel` falls after its last bit. A busy interval of `PROG_CYCLES` clocks then starts. While `sel` is high and no command is in progress, `sdout_en` is high and `sdout` shows 0 while busy and 1 once ready. With `sel` low, `sdout_en` is low.
- R8: Commands sent while busy are ignored, including their start bit. The status display stays in place while they are sent.
- R9: The status display ends at the start bit of the next accepted command.
- R10: Dropping `sel` before a command is complete abandons it. A write cut short programs nothing and starts no busy interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| sdin | input | 1 | Serial command, address and data input |
| sdout | output | 1 | Serial read data or ready/busy status |
| sdout_en | output | 1 | High when `sdout` is driven; low means released |

## Verification
The checks assume that `sel`, `sclk` and `sdin` change slowly compared with `clk`. Each level of `sclk` is taken to last several system clocks, so that the synchronizer sees every edge and a read word is loaded before the first data edge. `sdin` is assumed stable around each rising `sclk`. The stimulus meets these conditions by holding each `sclk` level for six clocks and changing `sdin` two clocks before each rising edge. `sel` is only changed while `sclk` is low. The busy interval is set to 600 clocks, which is longer than a whole ignored write command, so the status output can be observed throughout the command.

// File: rtl/se_pkg.sv
package se_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } se_state_e;

  typedef enum logic [1:0] {
    OPC_EXT   = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10,
    OPC_ERASE = 2'b11
  } se_opc_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_WRITE,
    PEND_ERASE
  } se_pend_e;

  localparam logic [1:0] EXT_ENABLE  = 2'b11;
  localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/se_pin_sampler.sv
module se_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic sel_q,
  output logic sdin_q,
  output logic sclk_rise
);

  localparam int LAST = SYNC_STAGES - 1;

  // bit 2: select, bit 1: serial clock, bit 0: data; all delayed alike
  logic [2:0] pipe [SYNC_STAGES];
  logic       sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b000;
      sclk_prev <= 1'b0;
    end else begin
      pipe[0] <= {sel, sclk, sdin};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_prev <= pipe[LAST][1];
    end
  end

  assign sel_q     = pipe[LAST][2];
  assign sdin_q    = pipe[LAST][0];
  assign sclk_rise = pipe[LAST][1] & ~sclk_prev;

endmodule

// File: rtl/se_cmd_decoder.sv
module se_cmd_decoder
  import se_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_q,
  input  logic              sdin_q,
  input  logic              sclk_rise,
  input  logic              busy,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              commit,
  output logic              commit_erase,
  output logic              wen,
  output logic              status_on,
  output logic              rd_drive,
  output logic              rd_bit
);

  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXW + 1);

  se_state_e         state;
  se_pend_e          pend;
  logic [1:0]        opc;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_sh;
  logic [1:0]        load_p;
  logic [ADDR_W-1:0] addr_next;
  logic [1:0]        ext_code;

  assign addr_next = {addr[ADDR_W-2:0], sdin_q};
  assign ext_code  = addr_next[ADDR_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAIT;
      pend         <= PEND_NONE;
      opc          <= 2'b00;
      cnt          <= '0;
      addr         <= '0;
      wdata        <= '0;
      rd_sh        <= '0;
      load_p       <= 2'b00;
      commit       <= 1'b0;
      commit_erase <= 1'b0;
      wen          <= 1'b0;
      status_on    <= 1'b0;
      rd_drive     <= 1'b0;
      rd_bit       <= 1'b0;
    end else begin
      commit <= 1'b0;
      load_p <= {load_p[0], 1'b0};
      if (load_p[1]) rd_sh <= mem_rdata;

      if (!sel_q) begin
        state    <= ST_WAIT;
        rd_drive <= 1'b0;
        rd_bit   <= 1'b0;
        if (pend != PEND_NONE) begin
          commit       <= 1'b1;
          commit_erase <= (pend == PEND_ERASE);
          status_on    <= 1'b1;
          pend         <= PEND_NONE;
        end
      end else if (sclk_rise) begin
        unique case (state)
          ST_WAIT: begin
            if (sdin_q && !busy) begin
              state     <= ST_OPC;
              cnt       <= '0;
              status_on <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], sdin_q};
            if (cnt == CNT_W'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr <= addr_next;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              unique case (se_opc_e'(opc))
                OPC_READ: begin
                  state    <= ST_READ;
                  rd_drive <= 1'b1;
                  rd_bit   <= 1'b0;
                  load_p   <= {load_p[0], 1'b1};
                end
                OPC_WRITE: begin
                  state <= wen ? ST_DATA : ST_HOLD;
                end
                OPC_ERASE: begin
                  if (wen) pend <= PEND_ERASE;
                  state <= ST_HOLD;
                end
                OPC_EXT: begin
                  if (ext_code == EXT_ENABLE) wen <= 1'b1;
                  else if (ext_code == EXT_DISABLE) wen <= 1'b0;
                  state <= ST_HOLD;
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            wdata <= {wdata[DATA_W-2:0], sdin_q};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              pend  <= PEND_WRITE;
              state <= ST_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (cnt == CNT_W'(DATA_W)) begin
              rd_drive <= 1'b0;
              rd_bit   <= 1'b0;
              state    <= ST_HOLD;
            end else begin
              rd_bit <= rd_sh[DATA_W-1];
              rd_sh  <= {rd_sh[DATA_W-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
          ST_HOLD: begin
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/se_prog_timer.sv
module se_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (start) begin
      remain <= TW'(PROG_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/se_word_array.sv
module se_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // power-up contents: every word in the erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/se_eeprom_slave.sv
module se_eeprom_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_en
);

  logic              sel_q;
  logic              sdin_q;
  logic              sclk_rise;
  logic              busy;
  logic              commit;
  logic              commit_erase;
  logic              wen;
  logic              status_on;
  logic              rd_drive;
  logic              rd_bit;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] mem_wdata;

  se_pin_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sclk     (sclk),
    .sdin     (sdin),
    .sel_q    (sel_q),
    .sdin_q   (sdin_q),
    .sclk_rise(sclk_rise)
  );

  se_cmd_decoder #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_decoder (
    .clk         (clk),
    .rst         (rst),
    .sel_q       (sel_q),
    .sdin_q      (sdin_q),
    .sclk_rise   (sclk_rise),
    .busy        (busy),
    .mem_rdata   (mem_rdata),
    .addr        (addr),
    .wdata       (wdata),
    .commit      (commit),
    .commit_erase(commit_erase),
    .wen         (wen),
    .status_on   (status_on),
    .rd_drive    (rd_drive),
    .rd_bit      (rd_bit)
  );

  se_prog_timer #(
    .PROG_CYCLES(PROG_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(commit),
    .busy (busy)
  );

  // programming can only clear bits unless the word is erased
  assign mem_wdata = commit_erase ? {DATA_W{1'b1}} : (mem_rdata & wdata);

  se_word_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk  (clk),
    .we   (commit),
    .waddr(addr),
    .wdata(mem_wdata),
    .raddr(addr),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdout    <= 1'b0;
      sdout_en <= 1'b0;
    end else if (rd_drive) begin
      sdout    <= rd_bit;
      sdout_en <= 1'b1;
    end else if (sel_q && status_on) begin
      sdout    <= ~busy;
      sdout_en <= 1'b1;
    end else begin
      sdout    <= 1'b0;
      sdout_en <= 1'b0;
    end
  end

endmodule

// File: rtl/se_eeprom_slave_chk.sv
module se_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic sel,
  input logic sdout,
  input logic sdout_en,
  input logic busy,
  input logic commit,
  input logic wen,
  input logic rd_drive
);

  // R1: reset leaves the output released and modify commands locked
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdout_en && !wen));

  // R3: the first driven read bit is the dummy zero
  p_read_dummy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_drive) |=> (sdout_en && !sdout));

  // R4: nothing is programmed while the enable latch is clear
  p_locked_no_prog_r4: assert property (@(posedge clk) disable iff (rst)
    commit |-> wen);

  // R7: programming always opens a busy interval
  p_commit_busy_r7: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy);

  // R7: output released once select has been low long enough to pass the pipeline
  p_sel_low_release_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel && !$past(sel) && !$past(sel, 2) && !$past(sel, 3) && !$past(sel, 4))
      |-> !sdout_en);

  // R8: no new programming starts inside a busy interval
  p_no_prog_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !commit);

endmodule

bind se_eeprom_slave se_eeprom_slave_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel     (sel),
  .sdout   (sdout),
  .sdout_en(sdout_en),
  .busy    (busy),
  .commit  (commit),
  .wen     (wen),
  .rd_drive(rd_drive)
);

// File: tb/se_eeprom_slave_bench.sv
`timescale 1ns/1ps
module se_eeprom_slave_bench;

  localparam int PROG = 600;
  localparam int H    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic sdout;
  logic sdout_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  se_eeprom_slave #(
    .PROG_CYCLES(PROG)
  ) u_se_eeprom_slave (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .sclk    (sclk),
    .sdin    (sdin),
    .sdout   (sdout),
    .sdout_en(sdout_en)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdin = b;
    idle(2);
    sclk = 1'b1;
    idle(H);
    sclk = 1'b0;
    idle(H);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic begin_cmd(input logic [1:0] opc, input logic [5:0] a, input int nlead);
    sel = 1'b1;
    idle(H);
    repeat (nlead) pulse(1'b0);
    pulse(1'b1);
    send({30'd0, opc}, 2);
    send({26'd0, a}, 6);
  endtask

  task automatic end_cmd;
    sel  = 1'b0;
    sdin = 1'b0;
    idle(H);
  endtask

  task automatic rd_word(input logic [5:0] a, input int nlead, output logic [15:0] d);
    begin_cmd(2'b10, a, nlead);
    check(sdout_en && !sdout, "R3 dummy zero", {sdout_en, sdout}, 2'b10);
    d = '0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b0);
      d = {d[14:0], sdout};
    end
    pulse(1'b0);
    check(!sdout_en, "R3 release after LSB", sdout_en, 0);
    end_cmd();
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [15:0] d);
    begin_cmd(2'b01, a, 0);
    send({16'd0, d}, 16);
    end_cmd();
  endtask

  task automatic erase_word(input logic [5:0] a);
    begin_cmd(2'b11, a, 0);
    end_cmd();
  endtask

  task automatic ext_cmd(input logic [5:0] a);
    begin_cmd(2'b00, a, 0);
    end_cmd();
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    sel = 1'b1;
    idle(H);
    while (!(sdout_en && sdout) && n < PROG + 100) begin
      idle(1);
      n++;
    end
    check(sdout_en && sdout, tag, {sdout_en, sdout}, 2'b11);
    end_cmd();
  endtask

  task automatic t_reset;
    check(!sdout_en, "R1 output released after reset", sdout_en, 0);
  endtask

  task automatic t_locked;
    logic [15:0] d;
    wr_word(6'd3, 16'h0000);
    sel = 1'b1;
    idle(H);
    check(!sdout_en, "R4 locked write starts no busy", sdout_en, 0);
    end_cmd();
    rd_word(6'd3, 0, d);
    check(d == 16'hFFFF, "R1 R4 locked write leaves word", d, 16'hFFFF);
  endtask

  task automatic t_status;
    ext_cmd(6'b110000);
    erase_word(6'd5);
    sel = 1'b1;
    idle(H);
    check(sdout_en && !sdout, "R7 busy shown", {sdout_en, sdout}, 2'b10);
    end_cmd();
    check(!sdout_en, "R7 released with select low", sdout_en, 0);
    wait_ready("R7 ready shown");
    sel = 1'b1;
    idle(H);
    check(sdout_en && sdout, "R9 ready before start", {sdout_en, sdout}, 2'b11);
    pulse(1'b1);
    check(!sdout_en, "R9 status ends at start bit", sdout_en, 0);
    end_cmd();
  endtask

  task automatic t_write_and;
    logic [15:0] d;
    wr_word(6'd5, 16'hA5A5);
    sel = 1'b1;
    idle(H);
    check(sdout_en && !sdout, "R7 busy after write", {sdout_en, sdout}, 2'b10);
    pulse(1'b1);
    send(32'h1, 2);
    send(32'd5, 6);
    send(32'h0000, 16);
    check(sdout_en && !sdout, "R8 status kept during ignored command", {sdout_en, sdout}, 2'b10);
    end_cmd();
    wait_ready("R7 ready after write");
    rd_word(6'd5, 0, d);
    check(d == 16'hA5A5, "R6 R8 written word", d, 16'hA5A5);
    wr_word(6'd5, 16'h0F0F);
    wait_ready("R7 ready after overwrite");
    rd_word(6'd5, 0, d);
    check(d == 16'h0505, "R6 write without erase gives AND", d, 16'h0505);
  endtask

  task automatic t_erase;
    logic [15:0] d;
    erase_word(6'd5);
    wait_ready("R7 ready after erase");
    rd_word(6'd5, 0, d);
    check(d == 16'hFFFF, "R5 erase sets all ones", d, 16'hFFFF);
  endtask

  task automatic t_bounds;
    logic [15:0] d;
    wr_word(6'd63, 16'h1234);
    wait_ready("R7 ready top word");
    wr_word(6'd0, 16'h8001);
    wait_ready("R7 ready bottom word");
    rd_word(6'd63, 0, d);
    check(d == 16'h1234, "R6 top address", d, 16'h1234);
    rd_word(6'd0, 0, d);
    check(d == 16'h8001, "R6 bottom address", d, 16'h8001);
  endtask

  task automatic t_start_bit;
    logic [15:0] d;
    rd_word(6'd63, 3, d);
    check(d == 16'h1234, "R2 leading zeros skipped", d, 16'h1234);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    begin_cmd(2'b01, 6'd7, 0);
    send(32'h00, 8);
    end_cmd();
    sel = 1'b1;
    idle(H);
    check(!sdout_en, "R10 cut write starts no busy", sdout_en, 0);
    end_cmd();
    rd_word(6'd7, 0, d);
    check(d == 16'hFFFF, "R10 cut write leaves word", d, 16'hFFFF);
  endtask

  task automatic t_disable;
    logic [15:0] d;
    ext_cmd(6'b100000);
    erase_word(6'd0);
    sel = 1'b1;
    idle(H);
    check(sdout_en && !sdout, "R4 code 10 keeps latch set", {sdout_en, sdout}, 2'b10);
    end_cmd();
    wait_ready("R7 ready after erase");
    ext_cmd(6'b000000);
    wr_word(6'd8, 16'h0000);
    sel = 1'b1;
    idle(H);
    check(!sdout_en, "R4 disabled write starts no busy", sdout_en, 0);
    end_cmd();
    rd_word(6'd8, 0, d);
    check(d == 16'hFFFF, "R4 disabled write leaves word", d, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    t_reset();
    t_locked();
    t_status();
    t_write_and();
    t_erase();
    t_bounds();
    t_start_bit();
    t_abort();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule